// File: doc/BRIEF.md
# Single-Channel Prescaled PWM Timer

This block produces one pulse-width-modulated output from a free-running up-counter. The counter advances on a clock divided by a selectable power of two. It counts from zero up to a programmable top value and then returns to zero. A second programmable threshold splits each period into an inactive part and an active part. A polarity bit chooses which output level counts as active. Software drives the block through a small synchronous register bus: an address, a write strobe, write data and registered read data.

Access to the registers depends on the enable state. The divide ratio and the polarity can only be set while the timer is disabled. The top value and the threshold can only be loaded while it is enabled. Each load of the top value or of the threshold starts a short transfer. After two divided-clock ticks, a per-register "load done" flag rises. The flag stays set until software writes a one to the matching bit of a clear register. A loaded top value or threshold is held in a staging register. It takes over at the next return of the counter to zero, so the period in progress is never cut short. A timer that is not counting picks the staged values up directly.

Register offsets: 0 control, 1 configuration, 2 top value, 3 threshold, 4 status, 5 flag clear.

Top module: `lpwm_timer`

## Requirements
- R1: After reset every readable register (offsets 0 to 4) reads zero and `pwm_o` is low.
- R2: Control register (offset 0): bit 0 is enable and bit 1 is run. A write sets enable from bit 0. Run becomes 1 only when bit 0 is 1, and then when bit 1 is 1 or run was already 1. Writing 0 stops the timer. While the timer is not running, the counter is held at 0, and `pwm_o` shows the inactive level, which equals the polarity bit. While the timer is disabled, the prescaler is held at 0. The control register reads back as {run, enable} in bits 1:0.
- R3: Configuration register (offset 1): bits 2:0 hold the divide exponent p and bit 3 holds the polarity. A write while enable is 1 is ignored.
- R4: Top value (offset 2) and threshold (offset 3) are CNT_W bits wide. A write to either while enable is 0 is ignored.
- R5: While enabled, the prescaler produces one tick every 2^p clocks, and the counter advances only on a tick.
- R6: While running, the counter steps 0, 1, ..., top and then returns to 0. One period lasts (top+1)·2^p clocks.
- R7: `pwm_o` is registered. It equals polarity XOR (running and counter > threshold), taken from the previous clock. With polarity 0 the output is high for (top − threshold)·2^p clocks of each period.
- R8: A loaded top value or threshold takes effect when the counter returns to 0. While the timer is not running, it takes effect in the cycle after the write.
- R9: Status register (offset 4): bit 0 is top-value load done and bit 1 is threshold load done. A flag sets on the second prescaler tick after the accepted write. A new write restarts the wait. Disabling the timer abandons a pending wait.
- R10: Writing a one to bit 0 or bit 1 of the clear register (offset 5) clears the matching flag. If a set and a clear fall in the same cycle, the set wins. Offset 5 reads zero.
- R11: `bus_rdata` shows the register selected by `bus_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pwm_o | output | 1 | PWM output |

## Verification
The hardest case to reach is the load-done timing under a large divide ratio. The flag then rises only on the second divided tick, and that tick depends on where the free-running prescaler happens to be when the write lands. The stimulus sets divide ratio 4 while the timer is disabled, loads new values while the timer is running, and leaves the bus address on the status register between transactions. As a result, the flag's rise is compared in every cycle against a behavioural model that tracks the prescaler phase. Changing the threshold in the middle of a period, and then counting output highs over whole periods, shows that the change waits for the wrap.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;
  localparam int ADDR_W     = 3;
  localparam int PRESC_W    = 3;
  localparam int FLAG_DELAY = 2;
  localparam int N_FLAGS    = 2;
  localparam int F_RELOAD   = 0;
  localparam int F_CMP      = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CFG    = 3'd1,
    A_RELOAD = 3'd2,
    A_CMP    = 3'd3,
    A_STAT   = 3'd4,
    A_CLR    = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic               pol;
    logic [PRESC_W-1:0] presc;
  } cfg_t;
endpackage

// File: rtl/lpwm_prescaler.sv
module lpwm_prescaler
  import lpwm_pkg::*;
#(
  parameter int P_W = PRESC_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [P_W-1:0] presc,
  output logic           tick
);
  localparam int DIV_W = (1 << P_W) - 1;

  logic [DIV_W-1:0] pcnt;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] limit;

  assign span  = (DIV_W+1)'(1) << presc;
  assign limit = DIV_W'(span - (DIV_W+1)'(1));
  assign tick  = en && (pcnt == limit);

  always_ff @(posedge clk) begin
    if (rst)       pcnt <= '0;
    else if (!en)  pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end

  p_pcnt_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pcnt == '0));
  p_pcnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    en |-> (pcnt <= limit));
endmodule

// File: rtl/lpwm_regs.sv
module lpwm_regs
  import lpwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic              run,
  output cfg_t              cfg,
  output logic [CNT_W-1:0]  arr_pre,
  output logic [CNT_W-1:0]  cmp_pre
);
  localparam int PEND_W = $clog2(FLAG_DELAY + 1);

  logic wr_ctrl, wr_cfg, wr_rel, wr_cmp, wr_clr;
  logic [N_FLAGS-1:0] upd;
  logic [N_FLAGS-1:0] flags;
  logic [N_FLAGS-1:0] fire;

  assign wr_ctrl = we && (addr == A_CTRL);
  assign wr_cfg  = we && (addr == A_CFG);
  assign wr_rel  = we && (addr == A_RELOAD);
  assign wr_cmp  = we && (addr == A_CMP);
  assign wr_clr  = we && (addr == A_CLR);

  assign upd[F_RELOAD] = wr_rel && en;
  assign upd[F_CMP]    = wr_cmp && en;

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      run <= 1'b0;
    end else if (wr_ctrl) begin
      en  <= wdata[0];
      run <= wdata[0] && (wdata[1] || run);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                cfg <= '0;
    else if (wr_cfg && !en) cfg <= cfg_t'(wdata[PRESC_W:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_pre <= '0;
      cmp_pre <= '0;
    end else begin
      if (upd[F_RELOAD]) arr_pre <= wdata[CNT_W-1:0];
      if (upd[F_CMP])    cmp_pre <= wdata[CNT_W-1:0];
    end
  end

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    logic [PEND_W-1:0] pend;
    assign fire[g] = tick && (pend == PEND_W'(1));

    always_ff @(posedge clk) begin
      if (rst)                            pend <= '0;
      else if (upd[g])                    pend <= PEND_W'(FLAG_DELAY);
      else if (!en)                       pend <= '0;
      else if (tick && (pend != '0))      pend <= pend - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst)                      flags[g] <= 1'b0;
      else if (fire[g])             flags[g] <= 1'b1;
      else if (wr_clr && wdata[g])  flags[g] <= 1'b0;
    end

    p_flag_clear_r10: assert property (@(posedge clk) disable iff (rst)
      (wr_clr && wdata[g] && !fire[g]) |=> !flags[g]);
    p_flag_on_tick_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[g]) |-> $past(tick));
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_CTRL:   rdata <= DATA_W'({run, en});
        A_CFG:    rdata <= DATA_W'(cfg);
        A_RELOAD: rdata <= DATA_W'(arr_pre);
        A_CMP:    rdata <= DATA_W'(cmp_pre);
        A_STAT:   rdata <= DATA_W'(flags);
        default:  rdata <= '0;
      endcase
    end
  end

  p_cfg_locked_r3: assert property (@(posedge clk) disable iff (rst)
    en |=> $stable(cfg));
  p_reload_locked_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(arr_pre) && $stable(cmp_pre)));
  p_run_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> en);
endmodule

// File: rtl/lpwm_core.sv
module lpwm_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             pol,
  input  logic [CNT_W-1:0] arr_pre,
  input  logic [CNT_W-1:0] cmp_pre,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] arr_act;
  logic [CNT_W-1:0] cmp_act;
  logic             at_top;
  logic             wrap;

  assign at_top = (cnt == arr_act);
  assign wrap   = run && tick && at_top;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= at_top ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_act <= '0;
      cmp_act <= '0;
    end else if (!run || wrap) begin
      arr_act <= arr_pre;
      cmp_act <= cmp_pre;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= pol ^ (run && (cnt > cmp_act));
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= arr_act));
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !(tick && at_top)) |=> ($stable(arr_act) && $stable(cmp_act)));
  p_idle_out_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pwm_o == $past(pol)));
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt));
endmodule

// File: rtl/lpwm_timer.sv
module lpwm_timer
  import lpwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_o
);
  logic             en, run, tick;
  cfg_t             cfg;
  logic [CNT_W-1:0] arr_pre, cmp_pre;

  lpwm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .tick(tick), .rdata(bus_rdata), .en(en), .run(run), .cfg(cfg),
    .arr_pre(arr_pre), .cmp_pre(cmp_pre)
  );

  lpwm_prescaler #(.P_W(PRESC_W)) presc_i (
    .clk(clk), .rst(rst), .en(en), .presc(cfg.presc), .tick(tick)
  );

  lpwm_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .pol(cfg.pol),
    .arr_pre(arr_pre), .cmp_pre(cmp_pre), .pwm_o(pwm_o)
  );
endmodule

// File: tb/lpwm_timer_tb_top.sv
module lpwm_timer_tb_top;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        bus_addr = 3'd4;
  logic              bus_we = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              pwm_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lpwm_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  // behavioural reference model
  int  m_en, m_run, m_presc, m_pol, m_arr, m_cmp, m_arr_a, m_cmp_a;
  int  m_pcnt, m_cnt, m_pend[2], m_flag[2], m_pwm, m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_run = 0; m_presc = 0; m_pol = 0; m_arr = 0; m_cmp = 0;
      m_arr_a = 0; m_cmp_a = 0; m_pcnt = 0; m_cnt = 0; m_pwm = 0; m_rd = 0;
      m_pend[0] = 0; m_pend[1] = 0; m_flag[0] = 0; m_flag[1] = 0;
    end else begin
      int tk, wr, a, d, n_cnt, n_pcnt, n_rd, n_pwm;
      int n_en, n_run, n_presc, n_pol, n_arr, n_cmp, n_arr_a, n_cmp_a;
      int n_pend[2], n_flag[2], up[2];
      a = int'(bus_addr); d = int'(bus_wdata); wr = bus_we;
      tk = (m_en != 0) && (m_pcnt == (1 << m_presc) - 1);
      n_pcnt = (m_en == 0 || tk) ? 0 : m_pcnt + 1;
      n_cnt = m_cnt;
      if (m_run == 0) n_cnt = 0;
      else if (tk) n_cnt = (m_cnt == m_arr_a) ? 0 : m_cnt + 1;
      n_arr_a = m_arr_a; n_cmp_a = m_cmp_a;
      if (m_run == 0 || (tk && m_cnt == m_arr_a)) begin
        n_arr_a = m_arr; n_cmp_a = m_cmp;
      end
      n_pwm = m_pol ^ ((m_run != 0 && m_cnt > m_cmp_a) ? 1 : 0);
      n_en = m_en; n_run = m_run; n_presc = m_presc; n_pol = m_pol;
      n_arr = m_arr; n_cmp = m_cmp;
      if (wr && a == 0) begin
        n_en = d & 1;
        n_run = ((d & 1) != 0 && ((d & 2) != 0 || m_run != 0)) ? 1 : 0;
      end
      if (wr && a == 1 && m_en == 0) begin
        n_presc = d & 7; n_pol = (d >> 3) & 1;
      end
      up[0] = wr && a == 2 && m_en != 0;
      up[1] = wr && a == 3 && m_en != 0;
      if (up[0]) n_arr = d & 16'hFFFF;
      if (up[1]) n_cmp = d & 16'hFFFF;
      for (int i = 0; i < 2; i++) begin
        n_pend[i] = m_pend[i];
        if (up[i]) n_pend[i] = 2;
        else if (m_en == 0) n_pend[i] = 0;
        else if (tk && m_pend[i] > 0) n_pend[i] = m_pend[i] - 1;
        n_flag[i] = m_flag[i];
        if (tk && m_pend[i] == 1) n_flag[i] = 1;
        else if (wr && a == 5 && ((d >> i) & 1) != 0) n_flag[i] = 0;
      end
      case (a)
        0: n_rd = (m_run << 1) | m_en;
        1: n_rd = (m_pol << 3) | m_presc;
        2: n_rd = m_arr;
        3: n_rd = m_cmp;
        4: n_rd = (m_flag[1] << 1) | m_flag[0];
        default: n_rd = 0;
      endcase
      m_en = n_en; m_run = n_run; m_presc = n_presc; m_pol = n_pol;
      m_arr = n_arr; m_cmp = n_cmp; m_arr_a = n_arr_a; m_cmp_a = n_cmp_a;
      m_pcnt = n_pcnt; m_cnt = n_cnt; m_pwm = n_pwm; m_rd = n_rd;
      for (int i = 0; i < 2; i++) begin
        m_pend[i] = n_pend[i]; m_flag[i] = n_flag[i];
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      compared++;
      if (pwm_o !== m_pwm[0]) begin
        mismatched++;
        $display("FAIL R7 model pwm_o: actual=%0b expected=%0d", pwm_o, m_pwm);
      end
      compared++;
      if (bus_rdata !== DATA_W'(m_rd)) begin
        mismatched++;
        $display("FAIL R11/R9 model rdata: actual=%0h expected=%0h", bus_rdata, m_rd);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = DATA_W'(d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 3'd4;
  endtask

  task automatic rd(input int a, output int v);
    bus_addr = 3'(a);
    @(negedge clk);
    v = int'(bus_rdata);
    bus_addr = 3'd4;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic highs(input int n, output int c);
    c = 0;
    repeat (n) begin
      if (pwm_o) c++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm_o", int'(pwm_o), 0);
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      chk("R1 register", v, 0);
    end
    // R4 loads ignored while disabled
    wr(2, 9); wr(3, 5);
    rd(2, v); chk("R4 top while disabled", v, 0);
    rd(3, v); chk("R4 threshold while disabled", v, 0);
    // R2 enable only; R3 config locked while enabled
    wr(0, 1);
    rd(0, v); chk("R2 enable without run", v, 1);
    wr(1, 15);
    rd(1, v); chk("R3 config while enabled", v, 0);
    // R9 load-done flags with divide 1
    wr(2, 9); wr(3, 5);
    idle(4);
    rd(4, v); chk("R9 both flags", v, 3);
    rd(5, v); chk("R10 clear reads zero", v, 0);
    wr(5, 1);
    rd(4, v); chk("R10 clear top flag", v, 2);
    wr(5, 2);
    rd(4, v); chk("R10 clear threshold flag", v, 0);
    // R6 R7 running waveform, divide 1
    wr(0, 3);
    rd(0, v); chk("R2 run", v, 3);
    idle(25);
    highs(10, v); chk("R7 R6 highs per period top9 thr5", v, 4);
    // R8 threshold change mid-period waits for wrap
    wr(3, 2);
    idle(25);
    highs(10, v); chk("R8 highs after threshold change", v, 7);
    // R2 stop, R3 config accepted while disabled
    wr(0, 0);
    idle(3);
    chk("R2 stopped output", int'(pwm_o), 0);
    wr(1, 10);
    rd(1, v); chk("R3 config while disabled", v, 10);
    idle(2);
    chk("R2 inactive level follows polarity", int'(pwm_o), 1);
    // R5 divide by 4, inverted polarity
    wr(0, 1);
    wr(5, 3);
    wr(3, 1);
    rd(4, v); chk("R9 flag not yet set", v, 0);
    wr(2, 4);
    wr(0, 3);
    idle(60);
    highs(20, v); chk("R5 R7 inverted highs top4 thr1 div4", v, 8);
    idle(10);
    rd(4, v); chk("R9 flags after divided ticks", v, 3);
    // R10 set and clear together: bench model compares exact cycle
    wr(3, 0);
    idle(1);
    wr(5, 2);
    idle(12);
    rd(4, v); chk("R9 R10 threshold flag after reload", (v >> 1) & 1, 1);
    wr(0, 0);
    idle(4);
    chk("R2 stop with inverted polarity", int'(pwm_o), 1);
    done = 1;
    summary();
    $finish;
  end
endmodule